// File: doc/BRIEF.md
# Serial SRAM Slave Front End with Hold

This block sits between a single-bit SPI host and a byte-wide synchronous memory array. The host selects the block, sends an opcode byte and a 24-bit address, and then streams data. A write streams bytes into the array. A read streams bytes back out of the array. An internal address counter moves to the next location after every complete byte. After the last location it returns to zero, so a long burst goes round the array without gaps.

The host pins are sampled by the block's own system clock, `clk`. The block detects SCK edges from those samples, so each SCK half-period must last at least four `clk` cycles. The serial output is modelled as a data bit and an enable. The enable drops at once while the block is deselected or held. An active-low hold input can freeze a transfer at any bit without aborting it. Hold is qualified by the SCK phase, so the host can pause and resume on either level of SCK.

The memory port has a one-cycle read latency. A read request in one cycle returns data on `mem_rdata` in the next cycle. A write is a single-cycle strobe that carries the address and the data.

Top module: `spi_sram_hold`

## Requirements
- R1: Out of reset, and at any time chip select (`cs_n`) is high, `so_oe` is low and the block performs no memory access.
- R2: After reset, the first period with `cs_n` low is ignored entirely: no memory access takes place and the output stays disabled. Commands are accepted only once `cs_n` has gone low and then high again.
- R3: Opcode 0x02 is a write. It is followed by a 24-bit address, sent MSB first, of which only the low log2(DEPTH) bits are used. Each following group of 8 bits, taken MSB first on SCK rising edges, is written to the array as one single-cycle `mem_we` strobe.
- R4: Opcode 0x03 is a read. `so_oe` stays low until the SCK falling edge that follows the last address bit. From that edge on, the array byte is driven MSB first, and `so` changes only on SCK falling edges.
- R5: After each complete data byte the address counter increments. From location DEPTH-1 it wraps to 0. This applies to both reads and writes.
- R6: Any other opcode value causes no memory access, and the output stays disabled until `cs_n` rises.
- R7: Raising `cs_n` ends the current command and clears the bit position. A partial byte is discarded, and the next selection starts again with a new opcode.
- R8: If `hold_n` falls while SCK is low, the pause begins at once. During the pause, SCK and SI activity is ignored and the bit position is kept.
- R9: If `hold_n` falls while SCK is high, the pause begins at the next SCK falling edge, and that falling edge still takes effect.
- R10: If `hold_n` rises while SCK is low, transfer resumes at once. If it rises while SCK is high, the pause lasts until the next SCK falling edge, and that edge has no effect.
- R11: During a read, `so_oe` drops as soon as `hold_n` falls and returns as soon as it rises, whatever the SCK level. The `so` bit is unchanged across the pause.
- R12: `mem_we` and `mem_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in (opcode, address, write data) |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high-impedance |
| mem_addr | output | log2(DEPTH) | Array address |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read request; data is expected on `mem_rdata` one cycle later |
| mem_rdata | input | 8 | Read data from the array |

## Verification
The bench writes a burst across the top of a 256-entry array and then reads the whole array plus a few extra bytes from an address with junk high bits. A counter that fails to wrap or to mask the high address bits shows up as wrong bytes. Each hold case is checked in a read, where a falling edge that is wrongly acted on or wrongly skipped shifts every later bit by one position. These cases are a pause entered while SCK is high, a release while SCK is high, and the immediate enable drop and return. Further runs send the first command before the block is armed, send an unknown opcode, and raise `cs_n` in the middle of an opcode and in the middle of a data byte. These catch a design that writes too early, acts on an unknown opcode, or keeps a stale bit count.

// File: rtl/spi_sram_hold.sv
`timescale 1ns/1ps
module spi_sram_hold #(
  parameter int DEPTH = 131072,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [4:0] ADDR_LAST = 5'd23;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_WR, PH_RD, PH_SKIP} phase_t;

  phase_t        phase;
  logic          sck_q, seen_low, armed, paused, is_rd, drive;
  logic          rd_req, rd_vld, ld_pend, we_q, so_q;
  logic [4:0]    cnt;
  logic [7:0]    sh, nxt, obuf, wdata_q;
  logic [AW-1:0] addr;

  wire active    = armed & ~cs_n;
  wire rise      = sck & ~sck_q;
  wire fall      = ~sck & sck_q;
  wire pause_now = paused ? ~(hold_n & ~sck) : (~hold_n & ~sck);
  wire rise_ev   = active & rise & ~paused;
  wire fall_ev   = active & fall & ~paused;
  wire [7:0] byte_in = {sh[6:0], si};
  wire [AW-1:0] addr_inc = (addr == AW'(DEPTH-1)) ? '0 : addr + AW'(1);

  assign so        = so_q;
  assign so_oe     = ~cs_n & hold_n & drive;
  assign mem_addr  = addr;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign mem_re    = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      sck_q    <= 1'b0;
      seen_low <= 1'b0;
      armed    <= 1'b0;
      paused   <= 1'b0;
      is_rd    <= 1'b0;
      drive    <= 1'b0;
      rd_req   <= 1'b0;
      rd_vld   <= 1'b0;
      ld_pend  <= 1'b0;
      we_q     <= 1'b0;
      so_q     <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      nxt      <= '0;
      obuf     <= '0;
      wdata_q  <= '0;
      addr     <= '0;
    end else begin
      sck_q    <= sck;
      seen_low <= seen_low | ~cs_n;
      armed    <= armed | (seen_low & cs_n);
      rd_req   <= 1'b0;
      we_q     <= 1'b0;
      rd_vld   <= rd_req;
      if (rd_vld) begin
        nxt     <= mem_rdata;
        ld_pend <= 1'b1;
      end
      if (we_q) addr <= addr_inc;
      if (cs_n) begin
        phase   <= PH_CMD;
        cnt     <= '0;
        paused  <= 1'b0;
        drive   <= 1'b0;
        ld_pend <= 1'b0;
      end else begin
        paused <= pause_now;
        if (rise_ev) begin
          case (phase)
            PH_CMD: begin
              sh <= byte_in;
              if (cnt == 5'd7) begin
                cnt   <= '0;
                is_rd <= (byte_in == OP_READ);
                phase <= (byte_in == OP_READ || byte_in == OP_WRITE) ? PH_ADDR : PH_SKIP;
              end else cnt <= cnt + 5'd1;
            end
            PH_ADDR: begin
              addr <= {addr[AW-2:0], si};
              if (cnt == ADDR_LAST) begin
                cnt    <= '0;
                phase  <= is_rd ? PH_RD : PH_WR;
                rd_req <= is_rd;
              end else cnt <= cnt + 5'd1;
            end
            PH_WR: begin
              sh <= byte_in;
              if (cnt == 5'd7) begin
                cnt     <= '0;
                we_q    <= 1'b1;
                wdata_q <= byte_in;
              end else cnt <= cnt + 5'd1;
            end
            PH_RD: begin
              if (cnt == 5'd7) begin
                cnt    <= '0;
                addr   <= addr_inc;
                rd_req <= 1'b1;
              end else cnt <= cnt + 5'd1;
            end
            default: ;
          endcase
        end
        if (fall_ev && phase == PH_RD) begin
          drive <= 1'b1;
          if (ld_pend) begin
            so_q    <= nxt[7];
            obuf    <= {nxt[6:0], 1'b0};
            ld_pend <= 1'b0;
          end else begin
            so_q <= obuf[7];
            obuf <= {obuf[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!mem_we && !mem_re && !so_oe)); // R2
  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_q && !sck) |=> $stable(so)); // R4
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == (($past(mem_addr) == AW'(DEPTH-1)) ? '0 : $past(mem_addr) + AW'(1))); // R5
  AST_DESEL_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cnt == '0); // R7
  AST_PAUSE_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    paused |=> $stable(cnt)); // R8
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R12

endmodule

// File: tb/spi_sram_hold_tb_top.sv
`timescale 1ns/1ps
module spi_sram_hold_tb_top;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic preload = 1'b1;
  logic so, so_oe, mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [DEPTH];
  int total = 0, fails = 0, we_cnt = 0, re_cnt = 0, oe_cnt = 0;

  always #4 clk = ~clk;

  spi_sram_hold #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] wr_val(input int i);
    return 8'((i * 13 + 1) & 255);
  endfunction
  function automatic logic [7:0] exp_mem(input int a);
    int k;
    k = (a - 250) & 255;
    return (k < 12) ? wr_val(k) : pat(a);
  endfunction

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
    end else if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (rst_n) begin
      if (mem_we) we_cnt <= we_cnt + 1;
      if (mem_re) re_cnt <= re_cnt + 1;
      if (so_oe)  oe_cnt <= oe_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask
  task automatic xbit(input logic b, output logic r);
    si = b; half(); r = so; sck = 1'b1; half(); sck = 1'b0;
  endtask
  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    logic t;
    for (int i = 7; i >= 0; i--) begin xbit(b[i], t); r[i] = t; end
  endtask
  task automatic sel();
    cs_n = 1'b0; half();
  endtask
  task automatic desel();
    half(); cs_n = 1'b1; half(); half();
  endtask
  task automatic cmd(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    xbyte(op, d); xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask
  task automatic garbage(input int n);
    for (int i = 0; i < n; i++) begin si = ~si; sck = 1'b1; half(); sck = 1'b0; half(); end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    logic [7:0] r, e;
    logic t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; preload = 1'b0;
    @(negedge clk);
    chk("R1 reset so_oe", so_oe, 0);
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset mem_re", mem_re, 0);

    sel(); cmd(8'h02, 24'h0); xbyte(8'hAA, r); desel();
    chk("R2 unarmed write", mem[0], pat(0));
    chk("R2 no strobe", we_cnt, 0);
    chk("R2 output off", oe_cnt, 0);

    sel(); xbyte(8'h05, r); xbyte(8'hFF, r); xbyte(8'hFF, r); xbyte(8'hFF, r); desel();
    chk("R6 no write", we_cnt, 0);
    chk("R6 no read", re_cnt, 0);
    chk("R6 output off", oe_cnt, 0);

    sel(); cmd(8'h02, 24'hAB00FA);
    for (int i = 0; i < 12; i++) xbyte(wr_val(i), r);
    desel();
    for (int i = 0; i < 12; i++) chk("R3 R5 write burst", mem[(250 + i) & 255], wr_val(i));
    chk("R3 strobe count", we_cnt, 12);

    sel(); cmd(8'h03, 24'hC30005);
    chk("R4 off before first fall", so_oe, 0);
    @(negedge clk);
    chk("R4 on after first fall", so_oe, 1);
    for (int k = 0; k < 260; k++) begin
      xbyte(8'h00, r);
      chk("R4 R5 read sweep", r, exp_mem((5 + k) & 255));
    end
    desel();
    chk("R1 off after deselect", so_oe, 0);

    sel(); cmd(8'h03, 24'h000010);
    xbyte(8'h00, r);
    chk("R11 first byte", r, exp_mem(16));
    e = exp_mem(17);
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, t); r[i] = t; end
    hold_n = 1'b0; #1;
    chk("R11 oe drops on hold", so_oe, 0);
    garbage(2);
    hold_n = 1'b1; #1;
    chk("R11 oe returns on release", so_oe, 1);
    chk("R8 bit kept across pause", so, e[4]);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, t); r[i] = t; end
    chk("R8 held read byte", r, e);
    xbyte(8'h00, r);
    chk("R8 read after hold", r, exp_mem(18));
    desel();

    sel(); cmd(8'h03, 24'h000020);
    e = exp_mem(32);
    for (int i = 7; i >= 4; i--) begin xbit(1'b0, t); r[i] = t; end
    si = 1'b0; half(); r[3] = so; sck = 1'b1;
    repeat (2) @(negedge clk);
    hold_n = 1'b0;
    repeat (2) @(negedge clk);
    sck = 1'b0; half();
    garbage(2);
    hold_n = 1'b1; half();
    for (int i = 2; i >= 0; i--) begin xbit(1'b0, t); r[i] = t; end
    chk("R9 hold entered while high", r, e);
    xbyte(8'h00, r);
    chk("R9 next byte", r, exp_mem(33));
    desel();

    sel(); cmd(8'h03, 24'h000030);
    e = exp_mem(48);
    for (int i = 7; i >= 6; i--) begin xbit(1'b0, t); r[i] = t; end
    hold_n = 1'b0; half();
    garbage(1);
    sck = 1'b1; half();
    hold_n = 1'b1; half();
    sck = 1'b0; half();
    for (int i = 5; i >= 0; i--) begin xbit(1'b0, t); r[i] = t; end
    chk("R10 release while high", r, e);
    xbyte(8'h00, r);
    chk("R10 next byte", r, exp_mem(49));
    desel();

    sel(); xbit(1'b0, t); xbit(1'b0, t); xbit(1'b0, t); desel();
    sel(); cmd(8'h02, 24'h000040); xbyte(8'h5A, r); desel();
    chk("R7 fresh command after abort", mem[8'h40], 8'h5A);
    sel(); cmd(8'h02, 24'h000041);
    for (int i = 0; i < 4; i++) xbit(1'b1, t);
    desel();
    chk("R7 partial byte dropped", mem[8'h41], pat(8'h41));

    sel(); cmd(8'h02, 24'h000060);
    e = 8'h9D;
    for (int i = 7; i >= 5; i--) xbit(e[i], t);
    hold_n = 1'b0; half();
    garbage(3);
    hold_n = 1'b1; half();
    for (int i = 4; i >= 0; i--) xbit(e[i], t);
    xbyte(8'h27, r);
    desel();
    chk("R8 held write byte", mem[8'h60], 8'h9D);
    chk("R8 write after hold", mem[8'h61], 8'h27);

    report();
  end
endmodule